// File: doc/BRIEF.md
# Dual-Format Video Pixel Front End

This block sits at the entry of a video encoder datapath. It accepts parallel pixels either as full-rate RGB on three byte lanes or as 4:2:2 luma/chroma on two byte lanes, and it turns each pixel into one normalised sample: an unsigned 8-bit luma value and two signed 8-bit colour-difference values. RGB pixels go through a fixed-point matrix. Studio-range luma/chroma pixels are offset-removed and stretched to full range.

The input clock may run at the pixel rate, or at twice the pixel rate. In the second case an internal divide-by-two phase marks every other edge as a pixel edge. A line-start marker restarts the chroma alternation, so that the first pixel of each line carries the blue-difference sample. Every captured pixel yields exactly one output strobe. The strobe comes after a fixed pipeline of three register stages, counted in pixel edges.

Top module: `pix_front`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. While it is low on an edge, `pix_valid` and all three output components go to 0, the chroma phase goes to U, and both held chroma samples go to 128. The divide-by-two phase is also cleared, so that in double-rate mode the first edge after release is a pixel edge.
- R2: With `dbl_rate` low, every clock edge is a pixel edge. A pixel sampled on edge n is presented with `pix_valid` high in the cycle that follows edge n+2.
- R3: With `dbl_rate` high, only alternate edges are pixel edges, starting with the first edge after reset. `pix_valid` is high for exactly one clock per pixel, and inputs must be held across both edges of a pixel.
- R4: If `line_sync` is high on a pixel edge, no pixel is captured and no strobe results. The chroma phase is reset, so the next captured pixel is a U pixel. The chroma phase toggles on every captured pixel of either format.
- R5: `fmt_sel[0]` = 0 selects RGB, with `px_a`=R, `px_b`=G and `px_c`=B, and `fmt_sel[1]` is ignored. `fmt_sel[0]` = 1 selects 4:2:2. In 4:2:2, `fmt_sel[1]` = 0 puts luma on `px_a` and chroma on `px_b`, `fmt_sel[1]` = 1 swaps the two lanes, and `px_c` is ignored.
- R6: RGB luma is Y = (77R + 150G + 29B) >> 8.
- R7: RGB chroma is U = sat((144·(B−Y) + 128) >>> 8) and V = sat((183·(R−Y) + 128) >>> 8). Here sat clamps to −128..127, and the result is output in two's complement.
- R8: 4:2:2 luma is ((Y−16)·298 + 128) >>> 8, clamped to 0..255.
- R9: In 4:2:2, the chroma lane carries U on pixels at phase 0 and V on pixels at phase 1. Each output uses the latest U and the latest V received, including the one in the current pixel. Each chroma sample therefore serves two pixels.
- R10: 4:2:2 chroma is sat(((C−128)·291 + 128) >>> 8), where sat clamps to −128..127.
- R11: The output components change only in a cycle where `pix_valid` is high. Otherwise they hold the last pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input data clock, at pixel rate or at twice pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| dbl_rate | input | 1 | 1 = clock runs at twice the pixel rate |
| fmt_sel | input | 2 | Input format and lane order |
| line_sync | input | 1 | Line-start marker; that pixel edge carries no pixel |
| px_a | input | 8 | Lane A: R, or luma or chroma in 4:2:2 |
| px_b | input | 8 | Lane B: G, or chroma or luma in 4:2:2 |
| px_c | input | 8 | Lane C: B; unused in 4:2:2 |
| pix_valid | output | 1 | One-clock strobe per output pixel |
| y_out | output | 8 | Luma, unsigned |
| u_out | output | 8 | Blue difference, two's complement |
| v_out | output | 8 | Red difference, two's complement |

## Verification
The assertions assume that `dbl_rate` stays steady over the pixels they reason about. The latency and strobe-spacing properties only fire after several cycles with a constant rate and no reset. The stimulus changes `dbl_rate` only while reset is held. In double-rate mode it holds each pixel for two full clocks, so a pixel is never sampled on its non-pixel edge. Format changes between pixels are allowed, and the table mixes them on purpose to show that the chroma phase counts pixels of both formats.

// File: rtl/pix_front.sv
module pix_front #(
  parameter int KYR = 77,
  parameter int KYG = 150,
  parameter int KYB = 29,
  parameter int KU  = 144,
  parameter int KV  = 183,
  parameter int KYS = 298,
  parameter int KCS = 291
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbl_rate,
  input  logic [1:0] fmt_sel,
  input  logic       line_sync,
  input  logic [7:0] px_a,
  input  logic [7:0] px_b,
  input  logic [7:0] px_c,
  output logic       pix_valid,
  output logic [7:0] y_out,
  output logic [7:0] u_out,
  output logic [7:0] v_out
);

  function automatic logic [7:0] sat_s(input logic signed [19:0] x);
    if (x > 20'sd127) return 8'h7f;
    else if (x < -20'sd128) return 8'h80;
    else return x[7:0];
  endfunction

  function automatic logic [7:0] sat_u(input logic signed [19:0] x);
    if (x < 20'sd0) return 8'h00;
    else if (x > 20'sd255) return 8'hff;
    else return x[7:0];
  endfunction

  // pixel-edge qualifier
  logic ph;
  wire  ce = dbl_rate ? ~ph : 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) ph <= 1'b0;
    else        ph <= dbl_rate ? ~ph : 1'b0;

  // stage 1: capture
  logic       s1_v, s1_yuv, s1_swap, s1_cph, cph;
  logic [7:0] s1_a, s1_b, s1_c;

  always_ff @(posedge clk)
    if (!rst_n) begin
      s1_v <= 1'b0; cph <= 1'b0; s1_yuv <= 1'b0; s1_swap <= 1'b0; s1_cph <= 1'b0;
      s1_a <= '0; s1_b <= '0; s1_c <= '0;
    end else if (ce) begin
      s1_v    <= ~line_sync;
      cph     <= line_sync ? 1'b0 : ~cph;
      s1_cph  <= cph;
      s1_yuv  <= fmt_sel[0];
      s1_swap <= fmt_sel[1];
      s1_a <= px_a; s1_b <= px_b; s1_c <= px_c;
    end

  // stage 2: luma matrix, chroma hold
  logic [15:0] lum_sum;
  logic [7:0]  lum, y_lane, c_lane;
  assign lum_sum = 16'(KYR * s1_a + KYG * s1_b + KYB * s1_c);
  assign lum     = 8'(lum_sum >> 8);
  assign y_lane  = s1_swap ? s1_b : s1_a;
  assign c_lane  = s1_swap ? s1_a : s1_b;

  logic       s2_v, s2_yuv;
  logic [7:0] s2_y, s2_r, s2_b, hold_u, hold_v;

  always_ff @(posedge clk)
    if (!rst_n) begin
      s2_v <= 1'b0; s2_yuv <= 1'b0; s2_y <= '0; s2_r <= '0; s2_b <= '0;
      hold_u <= 8'd128; hold_v <= 8'd128;
    end else if (ce) begin
      s2_v   <= s1_v;
      s2_yuv <= s1_yuv;
      s2_y   <= s1_yuv ? y_lane : lum;
      s2_r   <= s1_a;
      s2_b   <= s1_c;
      if (s1_v && s1_yuv) begin
        if (!s1_cph) hold_u <= c_lane;
        else         hold_v <= c_lane;
      end
    end

  // stage 3: scaling, rounding, saturation
  logic signed [19:0] d_b, d_r, c_u, c_v, y_n, t_u, t_v, t_y;
  assign d_b = $signed({12'd0, s2_b}) - $signed({12'd0, s2_y});
  assign d_r = $signed({12'd0, s2_r}) - $signed({12'd0, s2_y});
  assign c_u = $signed({12'd0, hold_u}) - 20'sd128;
  assign c_v = $signed({12'd0, hold_v}) - 20'sd128;
  assign y_n = $signed({12'd0, s2_y}) - 20'sd16;

  assign t_u = (s2_yuv ? c_u * 20'(KCS) : d_b * 20'(KU)) + 20'sd128;
  assign t_v = (s2_yuv ? c_v * 20'(KCS) : d_r * 20'(KV)) + 20'sd128;
  assign t_y = y_n * 20'(KYS) + 20'sd128;

  wire take = ce & s2_v;

  always_ff @(posedge clk)
    if (!rst_n) begin
      pix_valid <= 1'b0; y_out <= '0; u_out <= '0; v_out <= '0;
    end else begin
      pix_valid <= take;
      if (take) begin
        y_out <= s2_yuv ? sat_u(t_y >>> 8) : s2_y;
        u_out <= sat_s(t_u >>> 8);
        v_out <= sat_s(t_v >>> 8);
      end
    end

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pix_valid && y_out == 8'd0 && u_out == 8'd0 && v_out == 8'd0)); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n) &&
     !$past(dbl_rate, 3) && !$past(dbl_rate, 2) && !$past(dbl_rate))
    |-> (pix_valid == !$past(line_sync, 3))); // R2

  AST_DBL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && dbl_rate && $past(dbl_rate) && $past(rst_n)) |=> !pix_valid); // R3

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !pix_valid) |-> ($stable(y_out) && $stable(u_out) && $stable(v_out))); // R11

endmodule

// File: tb/tb_pix_front.sv
module tb_pix_front;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, dbl_rate = 1'b0, line_sync = 1'b1;
  logic [1:0] fmt_sel = 2'b00;
  logic [7:0] px_a = '0, px_b = '0, px_c = '0;
  logic       pix_valid;
  logic [7:0] y_out, u_out, v_out;

  pix_front dut (.clk(clk), .rst_n(rst_n), .dbl_rate(dbl_rate), .fmt_sel(fmt_sel),
    .line_sync(line_sync), .px_a(px_a), .px_b(px_b), .px_c(px_c),
    .pix_valid(pix_valid), .y_out(y_out), .u_out(u_out), .v_out(v_out));

  int total = 0, bad = 0;

  // {fmt_sel, line_sync, px_a, px_b, px_c}
  localparam int NV = 23;
  localparam logic [26:0] VEC [NV] = '{
    {2'b00, 1'b0, 8'd255, 8'd255, 8'd255},
    {2'b00, 1'b0, 8'd0,   8'd0,   8'd0  },
    {2'b00, 1'b0, 8'd255, 8'd0,   8'd0  },
    {2'b00, 1'b0, 8'd0,   8'd255, 8'd0  },
    {2'b00, 1'b0, 8'd0,   8'd0,   8'd255},
    {2'b00, 1'b0, 8'd0,   8'd255, 8'd255},
    {2'b00, 1'b0, 8'd18,  8'd52,  8'd200},
    {2'b01, 1'b1, 8'd0,   8'd0,   8'd0  },
    {2'b01, 1'b0, 8'd16,  8'd128, 8'd7  },
    {2'b01, 1'b0, 8'd235, 8'd240, 8'd7  },
    {2'b01, 1'b0, 8'd0,   8'd16,  8'd7  },
    {2'b01, 1'b0, 8'd255, 8'd255, 8'd7  },
    {2'b11, 1'b0, 8'd60,  8'd120, 8'd99 },
    {2'b11, 1'b0, 8'd200, 8'd80,  8'd0  },
    {2'b01, 1'b1, 8'd0,   8'd0,   8'd0  },
    {2'b01, 1'b0, 8'd100, 8'd0,   8'd0  },
    {2'b01, 1'b0, 8'd50,  8'd77,  8'd0  },
    {2'b00, 1'b0, 8'd100, 8'd100, 8'd100},
    {2'b01, 1'b0, 8'd90,  8'd30,  8'd0  },
    {2'b10, 1'b0, 8'd1,   8'd2,   8'd3  },
    {2'b00, 1'b1, 8'd0,   8'd0,   8'd0  },
    {2'b00, 1'b1, 8'd0,   8'd0,   8'd0  },
    {2'b00, 1'b1, 8'd0,   8'd0,   8'd0  }
  };

  function automatic int sat8(input int x);
    return (x > 127) ? 127 : ((x < -128) ? -128 : x);
  endfunction

  function automatic logic [23:0] rgb_exp(input int r, input int g, input int b);
    int y, u, v;
    y = (77 * r + 150 * g + 29 * b) >> 8;
    u = sat8((144 * (b - y) + 128) >>> 8);
    v = sat8((183 * (r - y) + 128) >>> 8);
    return {y[7:0], u[7:0], v[7:0]};
  endfunction

  function automatic logic [23:0] yuv_exp(input int yy, input int cu, input int cv);
    int y, u, v;
    y = ((yy - 16) * 298 + 128) >>> 8;
    y = (y < 0) ? 0 : ((y > 255) ? 255 : y);
    u = sat8(((cu - 128) * 291 + 128) >>> 8);
    v = sat8(((cv - 128) * 291 + 128) >>> 8);
    return {y[7:0], u[7:0], v[7:0]};
  endfunction

  // reference state
  logic       m_cph;
  logic [7:0] m_hu, m_hv;
  logic       pv [3];
  logic [23:0] pd [3];
  string      ptag [3];
  logic [23:0] held;

  task automatic chk(input string tag, input logic [24:0] got, input logic [24:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cph = 1'b0; m_hu = 8'd128; m_hv = 8'd128; held = '0;
    for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; pd[k] = '0; ptag[k] = "R4 R11 idle"; end
  endtask

  task automatic step(input logic [1:0] f, input logic s, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] c);
    logic [7:0] yl, cl;
    @(negedge clk);
    if (pv[2]) begin
      chk(ptag[2], {pix_valid, y_out, u_out, v_out}, {1'b1, pd[2]});
      held = pd[2];
    end else
      chk(ptag[2], {pix_valid, y_out, u_out, v_out}, {1'b0, held});
    for (int k = 2; k > 0; k--) begin pv[k] = pv[k-1]; pd[k] = pd[k-1]; ptag[k] = ptag[k-1]; end
    if (s) begin
      pv[0] = 1'b0; pd[0] = '0; ptag[0] = "R4 R11 sync"; m_cph = 1'b0;
    end else begin
      pv[0] = 1'b1;
      if (!f[0]) begin
        pd[0] = rgb_exp(int'(a), int'(b), int'(c)); ptag[0] = "R2 R5 R6 R7 rgb";
      end else begin
        yl = f[1] ? b : a; cl = f[1] ? a : b;
        if (!m_cph) m_hu = cl; else m_hv = cl;
        pd[0] = yuv_exp(int'(yl), int'(m_hu), int'(m_hv)); ptag[0] = "R5 R8 R9 R10 yuv";
      end
      m_cph = ~m_cph;
    end
    fmt_sel = f; line_sync = s; px_a = a; px_b = b; px_c = c;
  endtask

  task automatic do_reset(input logic dbl);
    @(negedge clk);
    rst_n = 1'b0; dbl_rate = dbl; line_sync = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {pix_valid, y_out, u_out, v_out}, 25'd0);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] e0, e1;
    do_reset(1'b0);
    for (int i = 0; i < NV; i++)
      step(VEC[i][26:25], VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

    // mid-stream reset restores chroma phase and held chroma (R1, R9)
    step(2'b01, 1'b0, 8'd80, 8'd200, 8'd0);
    step(2'b01, 1'b0, 8'd80, 8'd60,  8'd0);
    do_reset(1'b0);
    step(2'b01, 1'b0, 8'd80, 8'd30, 8'd0);
    step(2'b01, 1'b1, 8'd0, 8'd0, 8'd0);
    step(2'b01, 1'b1, 8'd0, 8'd0, 8'd0);
    step(2'b01, 1'b1, 8'd0, 8'd0, 8'd0);
    step(2'b01, 1'b1, 8'd0, 8'd0, 8'd0);

    // double-rate mode: first edge after reset is a pixel edge (R1, R3)
    do_reset(1'b1);
    e0 = rgb_exp(10, 200, 30);
    e1 = rgb_exp(240, 20, 90);
    fmt_sel = 2'b00; line_sync = 1'b0; px_a = 8'd10; px_b = 8'd200; px_c = 8'd30;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      case (k)
        5:       chk("R3 dbl first pixel", {pix_valid, y_out, u_out, v_out}, {1'b1, e0});
        6:       chk("R3 R11 dbl hold",    {pix_valid, y_out, u_out, v_out}, {1'b0, e0});
        7:       chk("R3 dbl second pixel", {pix_valid, y_out, u_out, v_out}, {1'b1, e1});
        8:       chk("R3 R11 dbl hold 2",  {pix_valid, y_out, u_out, v_out}, {1'b0, e1});
        default: chk("R1 R3 dbl latency",  {pix_valid, y_out, u_out, v_out}, 25'd0);
      endcase
      if (k == 2) begin px_a = 8'd240; px_b = 8'd20; px_c = 8'd90; end
      if (k == 4) line_sync = 1'b1;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule